// File: doc/BRIEF.md
# Edge-Interval Pulse Capture Unit

This block measures a single asynchronous, already demodulated data line. It reports the length of every high stretch and every low stretch in prescaled ticks. One free-running up-counter advances once every `PRESCALE` system clocks. Each rising edge of the synchronised input clears the counter and re-phases the tick. A falling edge therefore captures the high time directly. A rising edge captures the full high-plus-low span, and the stored high time is subtracted from it to give the low time.

Each finished interval is presented as one event: a level flag and a duration, offered on a valid/ready output. A downstream decoder is expected to consume the events. A single enable input arms the unit. When capture starts, the counter begins at zero. Removing the enable freezes the counter and throws away any event that has not been taken.

Top module: `pulse_interval_capture`

## Requirements
- R1: While reset is asserted and right after it, `ev_valid` and `ev_overrun` are 0.
- R2: A falling edge emits an event with `ev_level` = 1 and `ev_dur` = floor(H / PRESCALE), where H is the high time in clocks. The default PRESCALE is 64.
- R3: A rising edge clears the counter and the tick phase. It emits an event with `ev_level` = 0 whose `ev_dur` is the count at that edge minus the stored high count, which equals floor((H+L)/PRESCALE) - floor(H/PRESCALE).
- R4: The counter steps from `CNT_LIMIT` back to 0. The default limit is 2^31-2. Low durations are therefore taken modulo `CNT_LIMIT`+1, and no reported duration exceeds `CNT_LIMIT`.
- R5: The input passes through two synchronising flops. The event for an input change that lands before clock edge *a* becomes valid after edge *a*+2, and not before.
- R6: When capture is enabled, the counter and the stored high count start at 0. The first rising edge reports the low time counted from the first enabled clock, as floor((W+2)/PRESCALE) for an input raised W clocks after enable.
- R7: A pending event keeps its level and duration stable until it is accepted with `ev_valid` and `ev_ready` both high. `ev_valid` then drops, unless a new event arrives in the same cycle.
- R8: If a new interval completes while an event is pending and not accepted in that cycle, `ev_overrun` is set and stays set. The older event is kept and the new one is dropped.
- R9: With `en` low, the counter is held at 0 and `ev_valid` and `ev_overrun` clear on the next clock. Input edges produce no events.
- R10: A pulse shorter than PRESCALE clocks is still reported, with duration 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Capture enable; low returns the unit to idle |
| rf_in | input | 1 | Asynchronous demodulated data line |
| ev_ready | input | 1 | Consumer takes the pending event |
| ev_valid | output | 1 | An interval event is pending |
| ev_level | output | 1 | 1 = high interval ended, 0 = low interval ended |
| ev_dur | output | CNT_W | Interval length in prescaled ticks |
| ev_overrun | output | 1 | Sticky: an event was lost to a pending one |

## Verification
A table of high/low pairs is replayed. The pairs include intervals exactly on, one below and one above the tick period, very short pulses, and long runs. These separate a correct floor-of-ticks measure from an off-by-one phase after the clearing edge. They also tell a real low-time subtraction apart from reporting the raw span. A second instance with a tiny wrap limit drives both the high count and the low difference across the wrap point. This exposes a naive subtraction. Directed sequences hold the consumer off to create a collision, check the three-clock synchroniser latency, and toggle the input while disabled.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } pic_level_e;
endpackage

// File: rtl/pic_sync_edge.sv
module pic_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);
  // pipe_q[SYNC_STAGES-1] is the synchronised level, pipe_q[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[SYNC_STAGES-1:0], din};
  end

  assign rise_o = en &&  pipe_q[SYNC_STAGES-1] && !pipe_q[SYNC_STAGES];
  assign fall_o = en && !pipe_q[SYNC_STAGES-1] &&  pipe_q[SYNC_STAGES];

  AST_EDGE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !rise_o && !fall_o); // R9
endmodule

// File: rtl/pic_tick_counter.sv
module pic_tick_counter #(
  parameter int unsigned         PRESCALE  = 64,
  parameter int unsigned         CNT_W     = 31,
  parameter logic [CNT_W-1:0]    CNT_LIMIT = {{(CNT_W-1){1'b1}}, 1'b0}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rise_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned      PRE_W    = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] v);
    if (v == CNT_LIMIT) return '0;
    return v + CNT_W'(1);
  endfunction

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!en) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (rise_i) begin
      // the clearing edge counts as the first clock of a new tick period
      pre_q <= PRE_ONE;
      cnt_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + PRE_ONE;
      if (tick) cnt_q <= step_count(cnt_q);
    end
  end

  assign cnt_o = cnt_q;

  AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    en && rise_i |=> cnt_q == '0); // R3
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LIMIT); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt_q == '0); // R9
endmodule

// File: rtl/pic_capture.sv
module pic_capture #(
  parameter int unsigned      CNT_W     = 31,
  parameter logic [CNT_W-1:0] CNT_LIMIT = {{(CNT_W-1){1'b1}}, 1'b0}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic                new_o,
  output pic_pkg::pic_level_e lvl_o,
  output logic [CNT_W-1:0]    dur_o
);
  import pic_pkg::*;

  logic [CNT_W-1:0] hi_q;

  // modular difference on a counter that runs 0..CNT_LIMIT
  function automatic logic [CNT_W-1:0] span_less(input logic [CNT_W-1:0] now_v,
                                                 input logic [CNT_W-1:0] old_v);
    if (now_v >= old_v) return now_v - old_v;
    return now_v + (CNT_LIMIT - old_v) + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (!en)    hi_q <= '0;
    else if (fall_i) hi_q <= cnt_i;
  end

  assign new_o = rise_i || fall_i;
  assign lvl_o = fall_i ? LVL_HIGH : LVL_LOW;
  assign dur_o = fall_i ? cnt_i : span_less(cnt_i, hi_q);

  AST_DUR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    new_o |-> dur_o <= CNT_LIMIT); // R4
  AST_HIGH_START: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> hi_q == '0); // R6
endmodule

// File: rtl/pic_event_slot.sv
module pic_event_slot #(
  parameter int unsigned CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             new_i,
  input  logic             lvl_i,
  input  logic [CNT_W-1:0] dur_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             lvl_o,
  output logic [CNT_W-1:0] dur_o,
  output logic             ovf_o
);
  logic             valid_q, lvl_q, ovf_q;
  logic [CNT_W-1:0] dur_q;
  logic             stalled;

  assign stalled = valid_q && !ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      lvl_q   <= 1'b0;
      dur_q   <= '0;
      ovf_q   <= 1'b0;
    end else if (!en) begin
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (new_i) begin
      if (stalled) begin
        ovf_q <= 1'b1;
      end else begin
        valid_q <= 1'b1;
        lvl_q   <= lvl_i;
        dur_q   <= dur_i;
      end
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign lvl_o   = lvl_q;
  assign dur_o   = dur_q;
  assign ovf_o   = ovf_q;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    en && stalled |=> !en || (valid_q && $stable(lvl_q) && $stable(dur_q))); // R7
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    en && stalled && new_i |=> ovf_q || !en); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en && ovf_q |=> ovf_q || !en); // R8
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !valid_q && !ovf_q); // R9
endmodule

// File: rtl/pulse_interval_capture.sv
module pulse_interval_capture #(
  parameter int unsigned      PRESCALE    = 64,
  parameter int unsigned      CNT_W       = 31,
  parameter logic [CNT_W-1:0] CNT_LIMIT   = {{(CNT_W-1){1'b1}}, 1'b0},
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rf_in,
  input  logic             ev_ready,
  output logic             ev_valid,
  output logic             ev_level,
  output logic [CNT_W-1:0] ev_dur,
  output logic             ev_overrun
);
  import pic_pkg::*;

  logic             edge_rise, edge_fall;
  logic [CNT_W-1:0] run_cnt;
  logic             cap_new;
  pic_level_e       cap_lvl;
  logic [CNT_W-1:0] cap_dur;

  pic_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(en), .din(rf_in),
    .rise_o(edge_rise), .fall_o(edge_fall)
  );

  pic_tick_counter #(.PRESCALE(PRESCALE), .CNT_W(CNT_W), .CNT_LIMIT(CNT_LIMIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .rise_i(edge_rise), .cnt_o(run_cnt)
  );

  pic_capture #(.CNT_W(CNT_W), .CNT_LIMIT(CNT_LIMIT)) u_cap (
    .clk(clk), .rst_n(rst_n), .en(en), .rise_i(edge_rise), .fall_i(edge_fall),
    .cnt_i(run_cnt), .new_o(cap_new), .lvl_o(cap_lvl), .dur_o(cap_dur)
  );

  pic_event_slot #(.CNT_W(CNT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .en(en), .new_i(cap_new), .lvl_i(cap_lvl),
    .dur_i(cap_dur), .ready_i(ev_ready), .valid_o(ev_valid), .lvl_o(ev_level),
    .dur_o(ev_dur), .ovf_o(ev_overrun)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !ev_valid && !ev_overrun); // R1
endmodule

// File: tb/sim_pulse_interval_capture.sv
module sim_pulse_interval_capture;
  localparam int P  = 64;
  localparam int W0 = 100;
  localparam int NPAIR = 8;
  localparam int PAT_H [0:NPAIR-1] = '{64, 63, 2, 128, 300, 1000, 65, 5000};
  localparam int PAT_L [0:NPAIR-1] = '{64, 65, 3, 200, 70, 1000, 127, 3000};

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, rf_in = 1'b0, ev_ready = 1'b1;
  logic ev_valid, ev_level, ev_overrun;
  logic [30:0] ev_dur;
  logic en1 = 1'b0, din1 = 1'b0;
  logic v1, l1, o1;
  logic [2:0] d1;

  int nchk = 0, nerr = 0;
  bit done = 0, mon0 = 0, mon1 = 0;
  int n0 = 0, n1 = 0;
  logic        lv0 [0:63];
  longint      du0 [0:63];
  logic        lv1 [0:15];
  longint      du1 [0:15];
  logic        exl [0:63];
  longint      exd [0:63];

  always #10 clk = ~clk;

  pulse_interval_capture u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .rf_in(rf_in), .ev_ready(ev_ready),
    .ev_valid(ev_valid), .ev_level(ev_level), .ev_dur(ev_dur), .ev_overrun(ev_overrun)
  );

  pulse_interval_capture #(.PRESCALE(2), .CNT_W(3), .CNT_LIMIT(3'd5)) u1 (
    .clk(clk), .rst_n(rst_n), .en(en1), .rf_in(din1), .ev_ready(1'b1),
    .ev_valid(v1), .ev_level(l1), .ev_dur(d1), .ev_overrun(o1)
  );

  always @(negedge clk) begin
    if (mon0 && ev_valid && ev_ready && n0 < 64) begin
      lv0[n0] = ev_level; du0[n0] = longint'(ev_dur); n0++;
    end
    if (mon1 && v1 && n1 < 16) begin
      lv1[n1] = l1; du1[n1] = longint'(d1); n1++;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int k;
    wait_neg(3);
    chk("R1 valid in reset", longint'(ev_valid), 0);
    chk("R1 overrun in reset", longint'(ev_overrun), 0);
    rst_n = 1'b1;
    wait_neg(2);
    chk("R1 valid after reset", longint'(ev_valid), 0);

    // table walk on the default instance
    mon0 = 1; en = 1'b1;
    wait_neg(W0);
    rf_in = 1'b1;
    exl[0] = 1'b0; exd[0] = (W0 + 2) / P;
    k = 1;
    for (int i = 0; i < NPAIR; i++) begin
      wait_neg(PAT_H[i]); rf_in = 1'b0;
      wait_neg(PAT_L[i]); rf_in = 1'b1;
      exl[k] = 1'b1; exd[k] = PAT_H[i] / P; k++;
      exl[k] = 1'b0; exd[k] = (PAT_H[i] + PAT_L[i]) / P - PAT_H[i] / P; k++;
    end
    wait_neg(10);
    mon0 = 0;
    chk("R2 event count", n0, k);
    for (int i = 0; i < k; i++) begin
      string tag;
      if (i == 0) tag = "R6 first low";
      else if (exl[i]) tag = (PAT_H[(i-1)/2] < P) ? "R10 short high" : "R2 high";
      else tag = "R3 low";
      chk(tag, {lv0[i], du0[i][31:0]}, {exl[i], exd[i][31:0]});
    end

    // wrap on the small instance: PRESCALE 2, limit 5
    mon1 = 1; en1 = 1'b1;
    wait_neg(2); din1 = 1'b1;
    wait_neg(14); din1 = 1'b0;
    wait_neg(4);  din1 = 1'b1;
    wait_neg(4);  din1 = 1'b0;
    wait_neg(10); din1 = 1'b1;
    wait_neg(6);
    mon1 = 0;
    chk("R4 wrap event count", n1, 5);
    chk("R4 first low", {lv1[0], du1[0][31:0]}, {1'b0, 32'd2});
    chk("R4 high past wrap", {lv1[1], du1[1][31:0]}, {1'b1, 32'd1});
    chk("R4 low after wrapped high", {lv1[2], du1[2][31:0]}, {1'b0, 32'd2});
    chk("R4 high", {lv1[3], du1[3][31:0]}, {1'b1, 32'd2});
    chk("R4 low across wrap", {lv1[4], du1[4][31:0]}, {1'b0, 32'd5});

    // latency, hold, overrun, disable
    en = 1'b0; rf_in = 1'b0; ev_ready = 1'b0;
    wait_neg(5);
    en = 1'b1;
    wait_neg(200); rf_in = 1'b1;
    wait_neg(2);
    chk("R5 not yet valid", longint'(ev_valid), 0);
    wait_neg(1);
    chk("R5 valid after sync", longint'(ev_valid), 1);
    wait_neg(37); rf_in = 1'b0;
    wait_neg(8);
    chk("R8 overrun set", longint'(ev_overrun), 1);
    chk("R7 level held", longint'(ev_level), 0);
    chk("R8 older duration kept", longint'(ev_dur), 202 / P);
    ev_ready = 1'b1;
    wait_neg(1);
    ev_ready = 1'b0;
    chk("R7 valid drops after accept", longint'(ev_valid), 0);
    chk("R8 overrun sticky", longint'(ev_overrun), 1);
    en = 1'b0;
    wait_neg(1);
    chk("R9 overrun cleared", longint'(ev_overrun), 0);
    for (int i = 0; i < 4; i++) begin
      rf_in = ~rf_in; wait_neg(5);
    end
    chk("R9 no event while disabled", longint'(ev_valid), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule